// File: doc/BRIEF.md
# Program Bank Window and Mirroring Register Block

This block sits on the cartridge side of a 6502-style CPU bus and holds the mapping state for the 32 KB program area from $8000 to $FFFF. The area is split into four 8 KB windows. The two lower windows are switchable. Each one is loaded by a CPU write to one exact address. The two upper windows are always tied to the last two 8 KB banks of the program ROM. A third exact address selects one of four nametable mirroring arrangements.

The number of 8 KB banks in the ROM is a parameter. The fixed upper banks are derived from it. Any bank number written by software is folded modulo that count, so every bank output always names a bank that exists. All state is registered, and a write takes effect on the clock edge that samples the write strobe.

Top module: `prg_bank_mirror_ctrl`

## Requirements
- R1: A strobed write to address $8010 sets `bank_win0` to the written byte modulo `BANK_COUNT`.
- R2: A strobed write to address $A010 sets `bank_win1` to the written byte modulo `BANK_COUNT`.
- R3: `bank_win2` always equals `BANK_COUNT-2` and `bank_win3` always equals `BANK_COUNT-1`.
- R4: While reset is asserted and right after it is released, `bank_win0` is 0, `bank_win1` is 1 and `mirror_sel` is 0.
- R5: A strobed write to address $9400 sets `mirror_sel` to data bits 1:0, and data bits 7:2 are ignored. The encodings are 0 = vertical, 1 = horizontal, 2 = single-screen low and 3 = single-screen high.
- R6: A write to any other address leaves `bank_win0`, `bank_win1` and `mirror_sel` unchanged. This includes addresses one apart from a decoded one and the window base addresses. Bus activity with `wr_en` low also changes nothing.
- R7: `bank_win0` and `bank_win1` are always below `BANK_COUNT`. A written value equal to `BANK_COUNT` gives 0, and `BANK_COUNT-1` is kept as is.
- R8: Outputs change only at a rising clock edge. Inputs driven between edges do not show on the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, sampled on the rising edge |
| wr_addr | input | ADDR_W | CPU write address |
| wr_data | input | DATA_W | CPU write data |
| bank_win0 | output | BANK_W | 8 KB bank for $8000-$9FFF |
| bank_win1 | output | BANK_W | 8 KB bank for $A000-$BFFF |
| bank_win2 | output | BANK_W | 8 KB bank for $C000-$DFFF (fixed) |
| bank_win3 | output | BANK_W | 8 KB bank for $E000-$FFFF (fixed) |
| mirror_sel | output | 2 | Nametable mirroring mode |

## Verification
The corner that is hardest to reach is the fold of an out-of-range bank number. With a power-of-two bank count, dropping the high bits looks the same as a real modulo, so the bench uses a default count of 24. It then writes 24, 26 and 200 alongside 23 to catch both wrap errors and plain truncation. Writes to addresses next to the decoded ones ($8011, $9401) and to window bases ($A000) check that the decode is exact and not a range. A write with the strobe low checks that the strobe itself gates the registers.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;

    localparam logic [15:0] ADDR_LO_WIN  = 16'h8010;
    localparam logic [15:0] ADDR_HI_WIN  = 16'hA010;
    localparam logic [15:0] ADDR_MIRROR  = 16'h9400;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;

endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
    import prg_bank_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        hit_bank,
    output logic              hit_mirror
);

    always_comb begin
        hit_bank[0] = wr_en && (wr_addr == ADDR_W'(ADDR_LO_WIN));
        hit_bank[1] = wr_en && (wr_addr == ADDR_W'(ADDR_HI_WIN));
        hit_mirror  = wr_en && (wr_addr == ADDR_W'(ADDR_MIRROR));
    end

endmodule

// File: rtl/prg_bank_fold.sv
module prg_bank_fold #(
    parameter int DATA_W     = 8,
    parameter int BANK_COUNT = 24,
    parameter int BANK_W     = 5
) (
    input  logic [DATA_W-1:0] raw,
    output logic [BANK_W-1:0] folded
);

    localparam int WIDE_W = 32;

    logic [WIDE_W-1:0] raw_wide;

    always_comb begin
        raw_wide = WIDE_W'(raw);
        folded   = BANK_W'(raw_wide % WIDE_W'(BANK_COUNT));
    end

endmodule

// File: rtl/prg_bank_mirror_ctrl.sv
module prg_bank_mirror_ctrl
    import prg_bank_pkg::*;
#(
    parameter int  BANK_COUNT = 24,
    parameter int  ADDR_W     = 16,
    parameter int  DATA_W     = 8,
    localparam int BANK_W     = $clog2(BANK_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [BANK_W-1:0] bank_win0,
    output logic [BANK_W-1:0] bank_win1,
    output logic [BANK_W-1:0] bank_win2,
    output logic [BANK_W-1:0] bank_win3,
    output logic [1:0]        mirror_sel
);

    localparam int N_SW = 2;
    localparam logic [BANK_W-1:0] FIXED_PENULT = BANK_W'(BANK_COUNT - 2);
    localparam logic [BANK_W-1:0] FIXED_LAST   = BANK_W'(BANK_COUNT - 1);

    typedef struct packed {
        logic [N_SW-1:0][BANK_W-1:0] win;
        mirror_e                     mir;
    } regs_t;

    localparam regs_t REGS_RST = '{win: {BANK_W'(1), BANK_W'(0)}, mir: MIR_VERT};

    logic [N_SW-1:0]             hit_bank;
    logic                        hit_mirror;
    logic [N_SW-1:0][BANK_W-1:0] folded;
    regs_t                       regs_d, regs_q;

    prg_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .hit_bank   (hit_bank),
        .hit_mirror (hit_mirror)
    );

    for (genvar gi = 0; gi < N_SW; gi++) begin : g_fold
        prg_bank_fold #(
            .DATA_W     (DATA_W),
            .BANK_COUNT (BANK_COUNT),
            .BANK_W     (BANK_W)
        ) u_fold (
            .raw    (wr_data),
            .folded (folded[gi])
        );
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < N_SW; i++) begin
            if (hit_bank[i]) begin
                regs_d.win[i] = folded[i];
            end
        end
        if (hit_mirror) begin
            regs_d.mir = mirror_e'(wr_data[1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bank_win0  = regs_q.win[0];
    assign bank_win1  = regs_q.win[1];
    assign bank_win2  = FIXED_PENULT;
    assign bank_win3  = FIXED_LAST;
    assign mirror_sel = regs_q.mir;

endmodule

// File: rtl/prg_bank_mirror_chk.sv
module prg_bank_mirror_chk #(
    parameter int BANK_COUNT = 24,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int BANK_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [BANK_W-1:0] bank_win0,
    input logic [BANK_W-1:0] bank_win1,
    input logic [BANK_W-1:0] bank_win2,
    input logic [BANK_W-1:0] bank_win3,
    input logic [1:0]        mirror_sel
);

    logic is_lo, is_hi, is_mir;
    assign is_lo  = wr_en && (wr_addr == ADDR_W'(16'h8010));
    assign is_hi  = wr_en && (wr_addr == ADDR_W'(16'hA010));
    assign is_mir = wr_en && (wr_addr == ADDR_W'(16'h9400));

    a_r1_load_lo: assert property (@(posedge clk) disable iff (!rst_n)
        is_lo |=> 32'(bank_win0) == (32'($past(wr_data)) % 32'(BANK_COUNT)));

    a_r2_load_hi: assert property (@(posedge clk) disable iff (!rst_n)
        is_hi |=> 32'(bank_win1) == (32'($past(wr_data)) % 32'(BANK_COUNT)));

    a_r3_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
        32'(bank_win2) == 32'(BANK_COUNT - 2) && 32'(bank_win3) == 32'(BANK_COUNT - 1));

    a_r5_mirror_load: assert property (@(posedge clk) disable iff (!rst_n)
        is_mir |=> mirror_sel == $past(wr_data[1:0]));

    a_r6_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_lo || is_hi || is_mir) |=> $stable(bank_win0) && $stable(bank_win1) && $stable(mirror_sel));

    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(bank_win0) < 32'(BANK_COUNT) && 32'(bank_win1) < 32'(BANK_COUNT));

endmodule

bind prg_bank_mirror_ctrl prg_bank_mirror_chk #(
    .BANK_COUNT (BANK_COUNT),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .BANK_W     (BANK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .bank_win0  (bank_win0),
    .bank_win1  (bank_win1),
    .bank_win2  (bank_win2),
    .bank_win3  (bank_win3),
    .mirror_sel (mirror_sel)
);

// File: tb/sim_prg_bank_mirror_ctrl.sv
module sim_prg_bank_mirror_ctrl;

    localparam int NB = 24;
    localparam int BW = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [15:0]   wr_addr = 16'h0;
    logic [7:0]    wr_data = 8'h0;
    logic [BW-1:0] bank_win0, bank_win1, bank_win2, bank_win3;
    logic [1:0]    mirror_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    prg_bank_mirror_ctrl #(.BANK_COUNT(NB), .ADDR_W(16), .DATA_W(8)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .bank_win0  (bank_win0),
        .bank_win1  (bank_win1),
        .bank_win2  (bank_win2),
        .bank_win3  (bank_win3),
        .mirror_sel (mirror_sel)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  e0;
        logic [7:0]  e1;
        logic [1:0]  em;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{16'h8010, 8'h05, 8'd5,  8'd1,  2'd0},  // R1
        '{16'hA010, 8'h0A, 8'd5,  8'd10, 2'd0},  // R2
        '{16'h9400, 8'h01, 8'd5,  8'd10, 2'd1},  // R5 horizontal
        '{16'h9400, 8'hFE, 8'd5,  8'd10, 2'd2},  // R5 upper bits ignored
        '{16'h9400, 8'h07, 8'd5,  8'd10, 2'd3},  // R5
        '{16'h8010, 8'h1A, 8'd2,  8'd10, 2'd3},  // R7 26 mod 24
        '{16'hA010, 8'hC8, 8'd2,  8'd8,  2'd3},  // R7 200 mod 24
        '{16'h8011, 8'h11, 8'd2,  8'd8,  2'd3},  // R6 neighbour
        '{16'hA000, 8'h04, 8'd2,  8'd8,  2'd3},  // R6 window base
        '{16'h9401, 8'h00, 8'd2,  8'd8,  2'd3},  // R6 neighbour
        '{16'hC010, 8'h09, 8'd2,  8'd8,  2'd3},  // R6 other
        '{16'h8010, 8'h17, 8'd23, 8'd8,  2'd3},  // R7 top bank kept
        '{16'hA010, 8'h18, 8'd23, 8'd0,  2'd3},  // R7 count wraps to 0
        '{16'h9400, 8'h00, 8'd23, 8'd0,  2'd0}   // R5 vertical
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_fixed();
        chk("R3 win2", int'(bank_win2), NB - 2);
        chk("R3 win3", int'(bank_win3), NB - 1);
    endtask

    task automatic do_write(input logic en, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = en;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R4 win0 in reset", int'(bank_win0), 0);
        chk("R4 win1 in reset", int'(bank_win1), 1);
        chk("R4 mirror in reset", int'(mirror_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 win0 after reset", int'(bank_win0), 0);
        chk("R4 win1 after reset", int'(bank_win1), 1);
        chk("R4 mirror after reset", int'(mirror_sel), 0);
        chk_fixed();

        for (int i = 0; i < NV; i++) begin
            do_write(1'b1, VEC[i].addr, VEC[i].data);
            chk("R1/R7 win0", int'(bank_win0), int'(VEC[i].e0));
            chk("R2/R7 win1", int'(bank_win1), int'(VEC[i].e1));
            chk("R5/R6 mirror", int'(mirror_sel), int'(VEC[i].em));
            chk_fixed();
        end

        // R6: strobe low at a decoded address
        do_write(1'b0, 16'h8010, 8'h03);
        chk("R6 strobe low win0", int'(bank_win0), 23);
        do_write(1'b0, 16'h9400, 8'h02);
        chk("R6 strobe low mirror", int'(mirror_sel), 0);

        // R8: nothing shows before the edge
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 16'h8010;
        wr_data = 8'h04;
        #5;
        chk("R8 win0 before edge", int'(bank_win0), 23);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 win0 after edge", int'(bank_win0), 4);

        // R4: reset mid-run restores defaults
        do_write(1'b1, 16'h9400, 8'h01);
        rst_n = 1'b0;
        #3;
        chk("R4 win0 async reset", int'(bank_win0), 0);
        chk("R4 win1 async reset", int'(bank_win1), 1);
        chk("R4 mirror async reset", int'(mirror_sel), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_fixed();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule